// File: doc/BRIEF.md
# Debug Wait-In-Reset Controller

This block sits in front of a module's functional warm reset and lets a debugger keep that module in reset after the application has finished resetting it. A debugger sets a 3-bit reset-control command. While that command asks the block to wait in reset, any assertion of the application warm reset arms an internal hold. The hold keeps the module reset asserted after the application reset goes away.

The debugger frees the module with a single-cycle release strobe. This is the self-clearing write-one control; a cycle with the strobe low is the same as writing zero. The strobe only works when two conditions hold: the wait command is still selected, and the hold is the only thing keeping the module in reset. A strobe that arrives while the application reset is still asserted is discarded. The upper command codes cancel the hold outright, and the all-zero code returns the module to plain application control. A status output reports whether the module is currently in reset, so the debugger can read it back.

Top module: `wir_reset_ctrl`

## Requirements
- R1: After the block reset (`rst_n` low), the hold is clear, so `mod_rst_o` equals `app_rst_i`.
- R2: With command 000, `mod_rst_o` equals `app_rst_i` in every cycle.
- R3: With command 001, a cycle in which `app_rst_i` is high at a rising clock edge arms the hold. `mod_rst_o` then stays high without a gap after `app_rst_i` falls.
- R4: Command 001 never creates a reset on its own. While `app_rst_i` stays low and no hold is armed, `mod_rst_o` stays low.
- R5: A release strobe sampled while `app_rst_i` is high has no effect. The module is still held after the application reset ends.
- R6: A release strobe sampled with `app_rst_i` low, command 001 and the hold armed clears the hold. `mod_rst_o` goes low right after that clock edge.
- R7: Any command with bit 2 set (1xx) clears the hold at the next clock edge, and it cannot arm a hold.
- R8: Command 000 clears the hold at the next clock edge.
- R9: Reserved commands 010 and 011 neither arm nor release the hold. The hold keeps its value, and release strobes are ignored.
- R10: `in_reset_o` equals `mod_rst_o` at all times.
- R11: With no release strobe and no hold armed, the strobe input has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset, clears the hold |
| app_rst_i | input | 1 | Application functional warm reset, active high |
| rst_cmd_i | input | 3 | Debug reset-control command |
| release_i | input | 1 | One-cycle release strobe (write-one) |
| mod_rst_o | output | 1 | Reset to the controlled module, active high |
| in_reset_o | output | 1 | Status: module currently in reset |

## Verification
The hardest situation to reach from the ports is a release strobe that lands exactly on the edge where the application reset falls. A one-cycle application reset pulse that must still arm the hold is nearly as hard. Directed sequences place the strobe one cycle before, on, and after the falling edge of the reset. The random phase holds the wait command for long stretches with short and long application reset bursts and a dense strobe, so these alignments recur many times. A bench function that encodes the priority order predicts the expected output in each case.

// File: rtl/wir_pkg.sv
package wir_pkg;

  // Width of the debug reset-control command; the decoding below relies on 3 bits.
  localparam int unsigned CMD_W = 3;

  typedef enum logic [1:0] {
    WIR_NORMAL = 2'd0,
    WIR_WAIT   = 2'd1,
    WIR_RSVD   = 2'd2,
    WIR_CANCEL = 2'd3
  } wir_cmd_e;

  // Bit 2 has top priority (cancel), then bit 1 (reserved), then bit 0 (wait).
  function automatic wir_cmd_e wir_decode(input logic [CMD_W-1:0] c);
    if (c[2])      return WIR_CANCEL;
    else if (c[1]) return WIR_RSVD;
    else if (c[0]) return WIR_WAIT;
    else           return WIR_NORMAL;
  endfunction

  // Next value of the hold. Clearing beats arming, and arming beats release.
  function automatic logic wir_next_hold(input logic hold, input logic app_rst,
                                         input wir_cmd_e cmd, input logic rel);
    if (cmd == WIR_NORMAL || cmd == WIR_CANCEL) return 1'b0;
    if (cmd == WIR_WAIT && app_rst)             return 1'b1;
    if (cmd == WIR_WAIT && rel && hold)         return 1'b0;
    return hold;
  endfunction

endpackage

// File: rtl/wir_cmd_decode.sv
module wir_cmd_decode
  import wir_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output logic             is_normal_o,
  output logic             is_wait_o,
  output logic             is_rsvd_o,
  output logic             is_cancel_o
);

  wir_cmd_e kind;

  always_comb begin
    kind        = wir_decode(cmd_i);
    is_normal_o = (kind == WIR_NORMAL);
    is_wait_o   = (kind == WIR_WAIT);
    is_rsvd_o   = (kind == WIR_RSVD);
    is_cancel_o = (kind == WIR_CANCEL);
  end

endmodule

// File: rtl/wir_hold_latch.sv
module wir_hold_latch
  import wir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic app_rst_i,
  input  logic is_normal_i,
  input  logic is_wait_i,
  input  logic is_rsvd_i,
  input  logic is_cancel_i,
  input  logic release_i,
  output logic hold_o,
  output logic arm_o,
  output logic rel_ok_o,
  output logic clear_o
);

  logic     hold_q;
  logic     hold_d;
  wir_cmd_e kind;

  // Named internal events, brought out for the assertions.
  assign clear_o  = is_normal_i | is_cancel_i;
  assign arm_o    = is_wait_i & app_rst_i;
  assign rel_ok_o = is_wait_i & ~app_rst_i & release_i & hold_q;

  always_comb begin
    if (is_cancel_i)      kind = WIR_CANCEL;
    else if (is_rsvd_i)   kind = WIR_RSVD;
    else if (is_wait_i)   kind = WIR_WAIT;
    else                  kind = WIR_NORMAL;
    hold_d = wir_next_hold(hold_q, app_rst_i, kind, release_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_cancel_i |=> !hold_q);

  p_normal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_normal_i |=> !hold_q);

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wait_i && app_rst_i) |=> hold_q);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && is_wait_i && !app_rst_i && release_i) |=> !hold_q);

  p_release_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && app_rst_i && !clear_o) |=> hold_q);

  p_no_self_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !app_rst_i) |=> !hold_q);

  p_reserved_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_rsvd_i |=> $stable(hold_q));

endmodule

// File: rtl/wir_reset_ctrl.sv
module wir_reset_ctrl
  import wir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             app_rst_i,
  input  logic [CMD_W-1:0] rst_cmd_i,
  input  logic             release_i,
  output logic             mod_rst_o,
  output logic             in_reset_o
);

  logic is_normal, is_wait, is_rsvd, is_cancel;
  logic hold, arm_evt, rel_evt, clr_evt;

  wir_cmd_decode u_dec (
    .cmd_i       (rst_cmd_i),
    .is_normal_o (is_normal),
    .is_wait_o   (is_wait),
    .is_rsvd_o   (is_rsvd),
    .is_cancel_o (is_cancel)
  );

  wir_hold_latch u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .app_rst_i   (app_rst_i),
    .is_normal_i (is_normal),
    .is_wait_i   (is_wait),
    .is_rsvd_i   (is_rsvd),
    .is_cancel_i (is_cancel),
    .release_i   (release_i),
    .hold_o      (hold),
    .arm_o       (arm_evt),
    .rel_ok_o    (rel_evt),
    .clear_o     (clr_evt)
  );

  // The module stays in reset while the application holds it there or the debug hold is armed.
  assign mod_rst_o  = app_rst_i | hold;
  assign in_reset_o = mod_rst_o;

  // A falling application reset under the wait command must not open a gap.
  p_seamless_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(app_rst_i) && $past(is_wait) && is_wait) |-> mod_rst_o);

  // A release that happened while the application reset was high leaves the module held.
  p_late_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arm_evt) && is_wait && !rel_evt && !app_rst_i) |-> mod_rst_o);

  // After a valid release or a clear, the module leaves reset unless the application reasserts it.
  p_freed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_evt || clr_evt) |=> (mod_rst_o == app_rst_i));

endmodule

// File: tb/tb_wir_reset_ctrl.sv
`timescale 1ns/1ps
module tb_wir_reset_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       app_rst;
  logic [2:0] cmd;
  logic       rel;
  logic       mod_rst, in_reset;

  int n_tests = 0;
  int n_fail  = 0;
  logic mh; // bench model of the debug hold
  bit   done = 0;

  always #10 clk = ~clk; // 50 MHz

  wir_reset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .app_rst_i(app_rst), .rst_cmd_i(cmd),
    .release_i(rel), .mod_rst_o(mod_rst), .in_reset_o(in_reset)
  );

  // Restates the command rules: 000 and 1xx clear; 001 arms under app reset,
  // releases on a strobe outside app reset; 010/011 keep the hold.
  function automatic logic model_next(logic h, logic a, logic [2:0] c, logic s);
    logic clr, wt;
    clr = (c == 3'b000) || c[2];
    wt  = (c == 3'b001);
    if (clr)           return 1'b0;
    else if (wt && a)  return 1'b1;
    else if (wt && s)  return 1'b0;
    else               return h;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle's inputs, check the outputs against the model, then advance the model.
  task automatic cyc(input logic a, input logic [2:0] c, input logic s, input string tag);
    @(negedge clk);
    app_rst = a; cmd = c; rel = s;
    #1;
    check(mod_rst, a | mh, tag);
    check(in_reset, mod_rst, "R10");
    @(posedge clk);
    mh = model_next(mh, a, c, s);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    logic a; logic [2:0] c; logic s;
    seed_dummy = $urandom(32'd7);
    rst_n = 1'b0; app_rst = 1'b0; cmd = 3'b001; rel = 1'b0; mh = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(mod_rst, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R1: cleared hold, output follows app reset
    cyc(1'b0, 3'b000, 1'b0, "R1");
    // R2: normal mode follows
    cyc(1'b1, 3'b000, 1'b0, "R2");
    cyc(1'b1, 3'b000, 1'b0, "R2");
    cyc(1'b0, 3'b000, 1'b0, "R2");
    check(mod_rst, 1'b0, "R2");
    // R4: wait alone never resets
    for (int i = 0; i < 4; i++) cyc(1'b0, 3'b001, 1'b0, "R4");
    // R11: strobe with nothing armed
    cyc(1'b0, 3'b001, 1'b1, "R11");
    cyc(1'b0, 3'b000, 1'b1, "R11");
    // R3: single-cycle app reset pulse still arms, no gap
    cyc(1'b1, 3'b001, 1'b0, "R3");
    cyc(1'b0, 3'b001, 1'b0, "R3");
    check(mod_rst, 1'b1, "R3");
    cyc(1'b0, 3'b001, 1'b0, "R3");
    // R6: release frees on next edge
    cyc(1'b0, 3'b001, 1'b1, "R6");
    cyc(1'b0, 3'b001, 1'b0, "R6");
    check(mod_rst, 1'b0, "R6");
    // R5: release during app reset ignored
    cyc(1'b1, 3'b001, 1'b0, "R5");
    cyc(1'b1, 3'b001, 1'b1, "R5");
    cyc(1'b0, 3'b001, 1'b0, "R5");
    check(mod_rst, 1'b1, "R5");
    // R9: reserved codes keep hold and ignore strobe
    cyc(1'b0, 3'b010, 1'b1, "R9");
    cyc(1'b0, 3'b011, 1'b1, "R9");
    check(mod_rst, 1'b1, "R9");
    // R7: cancel clears
    cyc(1'b0, 3'b110, 1'b0, "R7");
    cyc(1'b0, 3'b001, 1'b0, "R7");
    check(mod_rst, 1'b0, "R7");
    // R7: cancel never arms
    cyc(1'b1, 3'b100, 1'b0, "R7");
    cyc(1'b0, 3'b100, 1'b0, "R7");
    check(mod_rst, 1'b0, "R7");
    // R9: reserved does not arm
    cyc(1'b1, 3'b011, 1'b0, "R9");
    cyc(1'b0, 3'b011, 1'b0, "R9");
    check(mod_rst, 1'b0, "R9");
    // R8: normal clears an armed hold
    cyc(1'b1, 3'b001, 1'b0, "R8");
    cyc(1'b0, 3'b000, 1'b0, "R8");
    cyc(1'b0, 3'b001, 1'b0, "R8");
    check(mod_rst, 1'b0, "R8");
    // R5/R6: strobe on the falling edge of app reset
    cyc(1'b1, 3'b001, 1'b1, "R5");
    cyc(1'b0, 3'b001, 1'b1, "R6");
    cyc(1'b0, 3'b001, 1'b0, "R6");
    check(mod_rst, 1'b0, "R6");

    // Constrained random: mostly wait command, bursty app reset, frequent strobes.
    a = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) a = ~a;
      case ($urandom_range(0, 9))
        0:       c = 3'b000;
        1:       c = 3'($urandom_range(2, 3));
        2:       c = 3'($urandom_range(4, 7));
        default: c = 3'b001;
      endcase
      s = ($urandom_range(0, 3) == 0);
      cyc(a, c, s, "R3");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule